// File: doc/BRIEF.md
# Event frame builder

This block turns one readout event into a byte stream for the link to the concentrator. A start strobe opens a frame. The block then sends a fixed part of 24 bytes, followed by the zero-suppressed payload that it passes through from an upstream byte FIFO. The payload ends at the input byte flagged last.

The fixed part has two sections. The first is a 4-byte header word made of the jumper settings, a 3-bit sending-status code and a 15-bit trigger number. The second is a status block of five 32-bit words. All header and status inputs are captured on the cycle the start strobe is accepted, so they may change once a frame is under way. The trigger number counts accepted starts.

The output is a valid/ready byte stream with a last flag. Serialisation onto the physical link is done elsewhere.

Top module: `evf_builder`

## Requirements
- R1: After reset, out_valid_o and in_ready_o are low and the first frame carries trigger number 0.
- R2: The first 4 bytes of a frame are the header word {jumper_i[13:0], send_stat_i[2:0], trigger[14:0]} (jumper in bits 31:18, status in bits 17:15, trigger in bits 14:0), sent most significant byte first.
- R3: Bytes 4 to 23 are five status words, each sent most significant byte first, in this order: fe_v_grp0_i, fe_v_grp1_i, fe_v_grp2_i, brd_volt_i, brd_err_i.
- R4: After byte 23, input bytes pass through unchanged, with in_ready_o equal to out_ready_i. While the block is idle or sending the fixed part, in_ready_o stays low and idle input produces no output.
- R5: out_last_o is high only on the payload byte that carries in_last_i. Accepting that byte ends the frame and returns the block to idle.
- R6: The trigger number increments by one per accepted start and wraps modulo 2^15.
- R7: While out_ready_i is low, a valid fixed-part byte stays on out_data_o, with out_valid_o held high.
- R8: A start strobe that arrives while a frame is in progress is ignored: it changes neither the trigger number nor the frame being sent.
- R9: Header and status inputs are captured when the start is accepted. Changes to them during the frame do not alter its bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Frame start strobe |
| jumper_i | input | 14 | Jumper settings for the header |
| send_stat_i | input | 3 | Sending-status code for the header |
| fe_v_grp0_i | input | 32 | Front-end voltages, card group 1 |
| fe_v_grp1_i | input | 32 | Front-end voltages, card group 2 |
| fe_v_grp2_i | input | 32 | Front-end voltages, card group 3 |
| brd_volt_i | input | 32 | Board voltages |
| brd_err_i | input | 32 | Board error status |
| in_data_i | input | 8 | Payload byte from the FIFO |
| in_valid_i | input | 1 | Payload byte valid |
| in_last_i | input | 1 | Final payload byte of the event |
| in_ready_o | output | 1 | Payload byte accepted |
| out_data_o | output | 8 | Output byte |
| out_valid_o | output | 1 | Output byte valid |
| out_last_o | output | 1 | Final byte of the frame |
| out_ready_i | input | 1 | Downstream ready |

## Verification
The assertions check on every cycle:
- a stalled fixed-part byte holds its value;
- the payload phase starts only after the last fixed byte has been taken;
- the trigger number steps by exactly one on an accepted start and stays frozen otherwise, so the wrap at 2^15 is covered without running 32768 frames;
- accepting the last byte returns the block to idle.

Only the bench scenarios can show that the bytes arrive in the right order with the right values. Those scenarios cover back-pressure patterns, payload lengths of one and several bytes, and a start strobe with changed header and status inputs sent in the middle of a frame.

// File: rtl/evf_pkg.sv
package evf_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 32;
  localparam int BYTES_PER_WORD = WORD_W / BYTE_W;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FIXED,
    ST_DATA
  } evf_state_e;
endpackage

// File: rtl/evf_trig_ctr.sv
module evf_trig_ctr #(
  parameter int TRG_W = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [TRG_W-1:0] cnt_o
);
  logic [TRG_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  a_r6_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i |=> $stable(cnt_q));
endmodule

// File: rtl/evf_seq.sv
module evf_seq
  import evf_pkg::*;
#(
  parameter int FIX_BYTES = 24,
  parameter int IDX_W     = $clog2(FIX_BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             out_ready_i,
  input  logic             in_valid_i,
  input  logic             in_last_i,
  output logic             accept_o,
  output evf_state_e       state_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FIX_BYTES - 1);

  evf_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  assign accept_o = (state_q == ST_IDLE) && start_i;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_FIXED;
        idx_d   = '0;
      end
      ST_FIXED: if (out_ready_i) begin
        if (idx_q == LAST_IDX) state_d = ST_DATA;
        else                   idx_d   = idx_q + 1'b1;
      end
      ST_DATA: if (in_valid_i && out_ready_i && in_last_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  assign state_o = state_q;
  assign idx_o   = idx_q;

  a_r3_idx_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q <= LAST_IDX);
  a_r4_data_after_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_DATA) ##1 (state_q == ST_DATA)
      |-> $past(state_q) == ST_FIXED && $past(idx_q) == LAST_IDX && $past(out_ready_i));
endmodule

// File: rtl/evf_snap.sv
module evf_snap
  import evf_pkg::*;
#(
  parameter int N_WORDS = 6,
  parameter int IDX_W   = 5
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            capture_i,
  input  logic [N_WORDS-1:0][WORD_W-1:0]  words_i,
  input  logic [IDX_W-1:0]                idx_i,
  output logic [BYTE_W-1:0]               byte_o
);
  localparam int LANE_W = $clog2(BYTES_PER_WORD);
  localparam int SEL_W  = IDX_W - LANE_W;

  logic [N_WORDS-1:0][WORD_W-1:0] snap_q;
  logic [SEL_W-1:0]               word_sel;
  logic [LANE_W-1:0]              lane;

  for (genvar w = 0; w < N_WORDS; w++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        snap_q[w] <= '0;
      else if (capture_i) snap_q[w] <= words_i[w];
    end
  end

  assign word_sel = idx_i[IDX_W-1:LANE_W];
  assign lane     = idx_i[LANE_W-1:0];

  // MSB-first lane order within each word
  always_comb begin
    byte_o = '0;
    for (int w = 0; w < N_WORDS; w++) begin
      if (word_sel == SEL_W'(w))
        byte_o = BYTE_W'(snap_q[w] >> (BYTE_W * (BYTES_PER_WORD - 1 - int'(lane))));
    end
  end
endmodule

// File: rtl/evf_builder.sv
module evf_builder
  import evf_pkg::*;
#(
  parameter int JMP_W  = 14,
  parameter int SST_W  = 3,
  parameter int TRG_W  = 15,
  parameter int N_STAT = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [JMP_W-1:0]  jumper_i,
  input  logic [SST_W-1:0]  send_stat_i,
  input  logic [31:0]       fe_v_grp0_i,
  input  logic [31:0]       fe_v_grp1_i,
  input  logic [31:0]       fe_v_grp2_i,
  input  logic [31:0]       brd_volt_i,
  input  logic [31:0]       brd_err_i,
  input  logic [7:0]        in_data_i,
  input  logic              in_valid_i,
  input  logic              in_last_i,
  output logic              in_ready_o,
  output logic [7:0]        out_data_o,
  output logic              out_valid_o,
  output logic              out_last_o,
  input  logic              out_ready_i
);
  localparam int N_WORDS   = N_STAT + 1;
  localparam int FIX_BYTES = N_WORDS * BYTES_PER_WORD;
  localparam int IDX_W     = $clog2(FIX_BYTES);

  logic                           accept;
  evf_state_e                     state;
  logic [IDX_W-1:0]               idx;
  logic [TRG_W-1:0]               trig_q;
  logic [N_WORDS-1:0][WORD_W-1:0] words;
  logic [BYTE_W-1:0]              fixed_byte;

  // word 0 goes out first
  assign words[0] = WORD_W'({jumper_i, send_stat_i, trig_q});
  assign words[1] = fe_v_grp0_i;
  assign words[2] = fe_v_grp1_i;
  assign words[3] = fe_v_grp2_i;
  assign words[4] = brd_volt_i;
  assign words[5] = brd_err_i;

  evf_seq #(.FIX_BYTES(FIX_BYTES), .IDX_W(IDX_W)) u_seq (
    .clk_i, .rst_ni, .start_i, .out_ready_i, .in_valid_i, .in_last_i,
    .accept_o(accept), .state_o(state), .idx_o(idx)
  );

  evf_trig_ctr #(.TRG_W(TRG_W)) u_trig (
    .clk_i, .rst_ni, .inc_i(accept), .cnt_o(trig_q)
  );

  evf_snap #(.N_WORDS(N_WORDS), .IDX_W(IDX_W)) u_snap (
    .clk_i, .rst_ni, .capture_i(accept), .words_i(words),
    .idx_i(idx), .byte_o(fixed_byte)
  );

  assign in_ready_o  = (state == ST_DATA) && out_ready_i;
  assign out_valid_o = (state == ST_FIXED) || ((state == ST_DATA) && in_valid_i);
  assign out_data_o  = (state == ST_DATA) ? in_data_i : fixed_byte;
  assign out_last_o  = (state == ST_DATA) && in_valid_i && in_last_i;

  a_r6_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> trig_q == TRG_W'($past(trig_q) + 1'b1));
  a_r8_busy_ignore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state != ST_IDLE) |=> $stable(trig_q));
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_FIXED && !out_ready_i) |=> out_valid_o && $stable(out_data_o));
  a_r5_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_last_o && out_ready_i) |=> state == ST_IDLE && !out_valid_o);
endmodule

// File: tb/evf_builder_tb.sv
module evf_builder_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        start = 0;
  logic [13:0] jumper = '0;
  logic [2:0]  sst = '0;
  logic [31:0] w1 = '0, w2 = '0, w3 = '0, w4 = '0, w5 = '0;
  logic [7:0]  in_data = '0;
  logic        in_valid = 0, in_last = 0, in_ready;
  logic [7:0]  out_data;
  logic        out_valid, out_last;
  logic        out_ready = 1;

  int          checks = 0, fails = 0;
  int          rdy_mode = 0;
  int          cycles = 0;
  logic [14:0] exp_trig = '0;
  logic [8:0]  exp_q[$];
  string       req_q[$];

  always #2 clk = ~clk;

  evf_builder u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .jumper_i(jumper), .send_stat_i(sst),
    .fe_v_grp0_i(w1), .fe_v_grp1_i(w2), .fe_v_grp2_i(w3), .brd_volt_i(w4), .brd_err_i(w5),
    .in_data_i(in_data), .in_valid_i(in_valid), .in_last_i(in_last), .in_ready_o(in_ready),
    .out_data_o(out_data), .out_valid_o(out_valid), .out_last_o(out_last), .out_ready_i(out_ready)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    case (rdy_mode)
      0: out_ready = 1'b1;
      1: out_ready = 1'($urandom % 2);
      default: out_ready = ~out_ready;
    endcase
  end

  // monitor / scoreboard
  logic       prev_stall = 0;
  logic [7:0] prev_data = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall) check(out_valid && out_data == prev_data, "R7 hold", out_data, prev_data);
      prev_stall = out_valid && !out_ready && !in_valid;
      prev_data  = out_data;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) check(0, "R4 unexpected byte", out_data, 0);
        else begin
          logic [8:0] e;
          string r;
          e = exp_q.pop_front();
          r = req_q.pop_front();
          check({out_last, out_data} == e, r, {out_last, out_data}, e);
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL R5 watchdog actual=hang expected=frame_end");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic push_word(input logic [31:0] w, input string r);
    for (int k = 0; k < 4; k++) begin
      exp_q.push_back({1'b0, w[31-8*k -: 8]});
      req_q.push_back(r);
    end
  endtask

  task automatic send_frame(input logic [13:0] j, input logic [2:0] s, input logic [31:0] seed,
                            input int n, input bit poke);
    jumper = j; sst = s;
    w1 = seed ^ 32'h1111_0001; w2 = seed ^ 32'h2222_0002; w3 = seed ^ 32'h3333_0003;
    w4 = seed ^ 32'h4444_0004; w5 = seed ^ 32'h5555_0005;
    push_word({j, s, exp_trig}, "R2 R6 header");
    push_word(w1, "R3 grp0"); push_word(w2, "R3 grp1"); push_word(w3, "R3 grp2");
    push_word(w4, "R3 brd_volt"); push_word(w5, "R3 brd_err");
    for (int i = 0; i < n; i++) begin
      exp_q.push_back({i == n - 1, 8'(seed[7:0] + i * 37)});
      req_q.push_back(i == n - 1 ? "R5 last" : "R4 data");
    end
    start = 1;
    @(posedge clk); #1;
    start = 0;
    exp_trig++;
    if (poke) begin
      repeat (3) @(posedge clk);
      #1;
      // R8 R9: new start with changed inputs mid-frame
      jumper = ~j; sst = ~s; w1 = ~w1; w2 = ~w2; w3 = ~w3; w4 = ~w4; w5 = ~w5;
      start = 1;
      @(posedge clk); #1;
      start = 0;
    end
    for (int i = 0; i < n; i++) begin
      in_valid = 1; in_data = 8'(seed[7:0] + i * 37); in_last = (i == n - 1);
      forever begin
        @(negedge clk);
        if (in_ready) break;
      end
      @(posedge clk); #1;
    end
    in_valid = 0; in_last = 0;
    while (exp_q.size() != 0) @(negedge clk);
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check(!out_valid, "R1 out_valid after reset", out_valid, 0);
    check(!in_ready, "R1 in_ready after reset", in_ready, 0);
    @(posedge clk); #1;
    // R4: idle input is not taken
    in_valid = 1; in_last = 1; in_data = 8'hA5;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(!in_ready && !out_valid, "R4 idle gate", {in_ready, out_valid}, 0);
    end
    @(posedge clk); #1;
    in_valid = 0; in_last = 0;
    // R1: first frame carries trigger 0, single-byte payload
    send_frame(14'h2A5C, 3'd5, 32'hDEAD_BEEF, 1, 0);
    rdy_mode = 1;
    send_frame(14'h3FFF, 3'd7, 32'h0123_4567, 5, 0);
    send_frame(14'h0001, 3'd2, 32'h89AB_CDEF, 3, 1);
    rdy_mode = 2;
    send_frame(14'h1234, 3'd1, 32'hF0F0_0F0F, 8, 1);
    rdy_mode = 0;
    send_frame(14'h0000, 3'd0, 32'h0000_0000, 2, 0);
    repeat (4) @(negedge clk);
    check(!out_valid, "R5 idle after frame", out_valid, 0);
    check(exp_q.size() == 0, "R5 all bytes seen", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule